// File: doc/BRIEF.md
# Keyed Configuration Item Data Port

This block lets a host pick one configuration item with a 16-bit key and then pull the item's bytes out one after another. Items sit in a small on-chip table. Each entry holds a byte store and a length. A simple load interface fills the table before the host starts reading. There are two banks of entries. Key bit 15 picks the bank, and bits 14:0 index an entry inside it.

The host reaches the block through three register ports, chosen by `req_port`:
- code 0 is a write-only selector;
- code 1 is a data register that returns up to `DATA_BYTES` bytes per access;
- code 2 is a combined port that takes both 1-byte data accesses and 2-byte key writes.

The block keeps the current entry and a 32-bit byte offset. Each returned byte advances the offset. Reads beyond the item give zeros. Every request gets a one-cycle response with an accept flag and read data.

Top module: `cfgkey_port`

## Requirements
- R1: After reset, key 0 of bank 0 is selected with offset zero, so the first 1-byte data read returns byte 0 of that entry.
- R2: On port code 0, only a write of size 2 is accepted. It loads the key from `req_wdata[15:0]` and clears the offset. Any other access there is refused (`rsp_ok`=0, `rsp_rdata`=0) and leaves the selection and offset untouched.
- R3: Key bit 15 selects bank 1 when set and bank 0 when clear. Key bits 14:0 give the entry index within that bank.
- R4: A key whose bits 14:0 are at or above `N_ENTRIES` leaves no entry selected. Data reads are then accepted and return zero.
- R5: A data read returns zero and leaves the offset unchanged in two cases: the entry's length is zero, or the offset is at or beyond the length.
- R6: A data read of size S returns S bytes in `rsp_rdata[8*S-1:0]`, with the first byte at bits `[8*S-1:8*S-8]`. If the item ends early, the low byte positions that were not filled are zero.
- R7: The offset advances by exactly the number of item bytes a read returned, so consecutive reads continue the stream.
- R8: On port code 2:
  - a size-1 read is a 1-byte data read;
  - a size-1 write is accepted and discarded;
  - a size-2 write is a key select;
  - every other combination is refused.
- R9: Data writes of an accepted size are acknowledged but change neither the item contents nor the offset.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. `rsp_ok` and `rsp_rdata` belong to that request.
- R11: On port code 1, sizes 0 and above `DATA_BYTES` are refused with zero data and no effect. Port code 3 refuses every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | 0 selector, 1 data, 2 combined, 3 unmapped |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 8*DATA_BYTES | Write data; key in bits 15:0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Access accepted |
| rsp_rdata | output | 8*DATA_BYTES | Read data, zero when refused |
| ld_byte_en | input | 1 | Load one byte into the table |
| ld_len_en | input | 1 | Load an entry length |
| ld_bank | input | 1 | Bank of the entry being loaded |
| ld_index | input | clog2(N_ENTRIES) | Entry index being loaded |
| ld_offset | input | clog2(ITEM_BYTES) | Byte position being loaded |
| ld_byte | input | 8 | Byte value to load |
| ld_len | input | clog2(ITEM_BYTES+1) | Length value, capped at ITEM_BYTES |

## Verification
Every result of a request is registered:
- the response strobe, the accept flag and the read data appear on the first rising edge after the request cycle;
- the new selection or offset shows in the next read's data.

The bench drives each request on a falling edge. It samples the response on the next falling edge, which is half a period after the edge that makes the response. It compares the response with a requirement-level model of the key, bank, length and offset. Refused and discarded accesses are followed by a read, so that any side effect would appear at the ports.

// File: rtl/cfgkey_pkg.sv
// Package: shared encodings for the keyed configuration item port.
// Assumes sizes fit in three bits (DATA_BYTES <= 7).
package cfgkey_pkg;

    localparam int KEY_W    = 16;
    localparam int BANK_BIT = 15;
    localparam int SIZE_W   = 3;

    typedef enum logic [1:0] {
        PORT_SEL  = 2'd0,
        PORT_DATA = 2'd1,
        PORT_COMB = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    // Decoded meaning of one request.
    typedef struct packed {
        logic              ok;
        logic              sel;
        logic              rd;
        logic [SIZE_W-1:0] rsize;
    } op_t;

endpackage

// File: rtl/cfgkey_decode.sv
// Module: cfgkey_decode
// Turns one host request into an accept flag, a select strobe or a read strobe.
// Accepted writes that are neither selects nor reads are dropped.
// Assumes req_valid is a one-cycle strobe.
module cfgkey_decode
    import cfgkey_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_port,
    input  logic [SIZE_W-1:0] req_size,
    output op_t               op
);

    // Classify the request by port, direction and size.
    always_comb begin
        op = '0;
        op.rsize = req_size;
        if (req_valid) begin
            unique case (port_e'(req_port))
                PORT_SEL: begin
                    if (req_write && req_size == SIZE_W'(2)) begin
                        op.ok  = 1'b1;
                        op.sel = 1'b1;
                    end
                end
                PORT_DATA: begin
                    if (req_size != '0 && int'(req_size) <= DATA_BYTES) begin
                        op.ok = 1'b1;
                        op.rd = !req_write;
                    end
                end
                PORT_COMB: begin
                    if (req_size == SIZE_W'(1)) begin
                        op.ok = 1'b1;
                        op.rd = !req_write;
                    end else if (req_write && req_size == SIZE_W'(2)) begin
                        op.ok  = 1'b1;
                        op.sel = 1'b1;
                    end
                end
                default: op.ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cfgkey_table.sv
// Module: cfgkey_table
// Two banks of item entries, each with a byte store and a length.
// Gives DATA_BYTES consecutive bytes from any offset in parallel.
// Assumes lengths never exceed ITEM_BYTES; larger loaded values are capped.
module cfgkey_table #(
    parameter int N_ENTRIES  = 8,
    parameter int ITEM_BYTES = 16,
    parameter int DATA_BYTES = 4,
    localparam int IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int BYTE_W = (ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1,
    localparam int LEN_W  = $clog2(ITEM_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_byte_en,
    input  logic                       ld_len_en,
    input  logic                       ld_bank,
    input  logic [IDX_W-1:0]           ld_index,
    input  logic [BYTE_W-1:0]          ld_offset,
    input  logic [7:0]                 ld_byte,
    input  logic [LEN_W-1:0]           ld_len,
    input  logic                       rd_bank,
    input  logic [IDX_W-1:0]           rd_index,
    input  logic [31:0]                rd_offset,
    output logic [LEN_W-1:0]           rd_len,
    output logic [DATA_BYTES-1:0][7:0] rd_lanes
);

    localparam int SLOTS = 2 * (1 << IDX_W);

    logic [7:0]       store_q [SLOTS][ITEM_BYTES];
    logic [LEN_W-1:0] len_q   [SLOTS];
    logic [IDX_W:0]   ld_slot;
    logic [IDX_W:0]   rd_slot;

    assign ld_slot = {ld_bank, ld_index};
    assign rd_slot = {rd_bank, rd_index};
    assign rd_len  = len_q[rd_slot];

    // Byte store: written only by the load interface.
    always_ff @(posedge clk) begin
        if (ld_byte_en && int'(ld_offset) < ITEM_BYTES)
            store_q[ld_slot][ld_offset] <= ld_byte;
    end

    // Lengths: cleared by reset, loaded and capped by the load interface.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) len_q[s] <= '0;
        end else if (ld_len_en) begin
            len_q[ld_slot] <= (int'(ld_len) > ITEM_BYTES) ? LEN_W'(ITEM_BYTES) : ld_len;
        end
    end

    // One read lane per byte of the widest access.
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        logic [31:0] pos;
        assign pos = rd_offset + 32'(g);
        assign rd_lanes[g] = (pos < 32'(ITEM_BYTES)) ? store_q[rd_slot][pos[BYTE_W-1:0]] : 8'h00;
    end

endmodule

// File: rtl/cfgkey_cursor.sv
// Module: cfgkey_cursor
// Holds the current entry and the byte offset.
// Packs the bytes of each read with the first byte most significant.
// Registers the response data.
// Assumes op comes from cfgkey_decode in the same cycle.
module cfgkey_cursor
    import cfgkey_pkg::*;
#(
    parameter int N_ENTRIES  = 8,
    parameter int ITEM_BYTES = 16,
    parameter int DATA_BYTES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int LEN_W = $clog2(ITEM_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  op_t                        op,
    input  logic [KEY_W-1:0]           key_in,
    input  logic [LEN_W-1:0]           tbl_len,
    input  logic [DATA_BYTES-1:0][7:0] tbl_lanes,
    output logic                       cur_bank,
    output logic [IDX_W-1:0]           cur_index,
    output logic [31:0]                cur_offset,
    output logic                       rsp_ok,
    output logic [8*DATA_BYTES-1:0]    rsp_data
);

    logic                    cur_valid_q;
    logic                    bank_q;
    logic [IDX_W-1:0]        index_q;
    logic [31:0]             off_q;
    logic [KEY_W-2:0]        key_idx;
    logic                    key_in_range;
    logic [31:0]             avail;
    logic [31:0]             take;
    logic [8*DATA_BYTES-1:0] packed_data;

    assign key_idx      = key_in[KEY_W-2:0];
    assign key_in_range = 32'(key_idx) < 32'(N_ENTRIES);
    assign cur_bank     = bank_q;
    assign cur_index    = index_q;
    assign cur_offset   = off_q;

    // Bytes left in the selected item, and how many this read takes.
    always_comb begin
        avail = '0;
        if (cur_valid_q && off_q < 32'(tbl_len))
            avail = 32'(tbl_len) - off_q;
        take = (avail < 32'(op.rsize)) ? avail : 32'(op.rsize);
    end

    // Put the taken bytes first-most-significant into the low rsize bytes.
    always_comb begin
        packed_data = '0;
        for (int g = 0; g < DATA_BYTES; g++) begin
            if (32'(g) < take)
                packed_data[8*(int'(op.rsize)-1-g) +: 8] = tbl_lanes[g];
        end
    end

    // Selection and offset: reset to key 0; select reloads; read advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid_q <= (N_ENTRIES > 0);
            bank_q      <= 1'b0;
            index_q     <= '0;
            off_q       <= '0;
        end else if (op.sel) begin
            cur_valid_q <= key_in_range;
            bank_q      <= key_in[BANK_BIT];
            index_q     <= IDX_W'(key_idx);
            off_q       <= '0;
        end else if (op.rd) begin
            off_q <= off_q + take;
        end
    end

    // Response register: accept flag and read data of this request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok   <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_ok   <= op.ok;
            rsp_data <= op.rd ? packed_data : '0;
        end
    end

    AST_SEL_CLEARS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        op.sel |=> off_q == 32'd0);  // R2
    AST_OFFSET_NO_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        !op.sel |=> off_q >= $past(off_q));  // R7
    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        op.rd |=> (off_q - $past(off_q)) <= 32'(DATA_BYTES));  // R7
    AST_OFFSET_IN_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= 32'(ITEM_BYTES));  // R5
    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op.rd && !cur_valid_q) |=> rsp_data == '0);  // R4

endmodule

// File: rtl/cfgkey_port.sv
// Module: cfgkey_port
// Top of the keyed configuration item port: decode, entry table and cursor.
// Each request gets a response one cycle later.
// Assumes the table is loaded before the host reads.
module cfgkey_port
    import cfgkey_pkg::*;
#(
    parameter int N_ENTRIES  = 8,
    parameter int ITEM_BYTES = 16,
    parameter int DATA_BYTES = 4
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                req_valid,
    input  logic                                                req_write,
    input  logic [1:0]                                          req_port,
    input  logic [2:0]                                          req_size,
    input  logic [8*DATA_BYTES-1:0]                             req_wdata,
    output logic                                                rsp_valid,
    output logic                                                rsp_ok,
    output logic [8*DATA_BYTES-1:0]                             rsp_rdata,
    input  logic                                                ld_byte_en,
    input  logic                                                ld_len_en,
    input  logic                                                ld_bank,
    input  logic [((N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1)-1:0] ld_index,
    input  logic [((ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1)-1:0] ld_offset,
    input  logic [7:0]                                          ld_byte,
    input  logic [$clog2(ITEM_BYTES + 1)-1:0]                   ld_len
);

    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int LEN_W = $clog2(ITEM_BYTES + 1);

    op_t                       op;
    logic                      cur_bank;
    logic [IDX_W-1:0]          cur_index;
    logic [31:0]               cur_offset;
    logic [LEN_W-1:0]          tbl_len;
    logic [DATA_BYTES-1:0][7:0] tbl_lanes;

    cfgkey_decode #(.DATA_BYTES(DATA_BYTES)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_port  (req_port),
        .req_size  (req_size),
        .op        (op)
    );

    cfgkey_table #(
        .N_ENTRIES(N_ENTRIES), .ITEM_BYTES(ITEM_BYTES), .DATA_BYTES(DATA_BYTES)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_byte_en (ld_byte_en),
        .ld_len_en  (ld_len_en),
        .ld_bank    (ld_bank),
        .ld_index   (ld_index),
        .ld_offset  (ld_offset),
        .ld_byte    (ld_byte),
        .ld_len     (ld_len),
        .rd_bank    (cur_bank),
        .rd_index   (cur_index),
        .rd_offset  (cur_offset),
        .rd_len     (tbl_len),
        .rd_lanes   (tbl_lanes)
    );

    cfgkey_cursor #(
        .N_ENTRIES(N_ENTRIES), .ITEM_BYTES(ITEM_BYTES), .DATA_BYTES(DATA_BYTES)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .key_in     (req_wdata[KEY_W-1:0]),
        .tbl_len    (tbl_len),
        .tbl_lanes  (tbl_lanes),
        .cur_bank   (cur_bank),
        .cur_index  (cur_index),
        .cur_offset (cur_offset),
        .rsp_ok     (rsp_ok),
        .rsp_data   (rsp_rdata)
    );

    // Response strobe: follows each request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R10
    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> rsp_rdata == '0);  // R11

endmodule

// File: tb/sim_cfgkey_port.sv
// Bench for cfgkey_port.
// Directed scenarios are checked against a requirement-level model.
module sim_cfgkey_port;

    localparam int NE = 8;
    localparam int IB = 16;
    localparam int DB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_port = 2'd0;
    logic [2:0]  req_size = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [31:0] rsp_rdata;
    logic        ld_byte_en = 1'b0;
    logic        ld_len_en = 1'b0;
    logic        ld_bank = 1'b0;
    logic [2:0]  ld_index = '0;
    logic [3:0]  ld_offset = '0;
    logic [7:0]  ld_byte = '0;
    logic [4:0]  ld_len = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    int  mlen [16];
    bit  m_valid;
    bit  m_bank;
    int  m_idx;
    int  m_off;

    always #10 clk = ~clk;

    cfgkey_port #(.N_ENTRIES(NE), .ITEM_BYTES(IB), .DATA_BYTES(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .ld_byte_en(ld_byte_en), .ld_len_en(ld_len_en), .ld_bank(ld_bank),
        .ld_index(ld_index), .ld_offset(ld_offset), .ld_byte(ld_byte), .ld_len(ld_len)
    );

    function automatic logic [7:0] pat(input bit b, input int i, input int o);
        return {b, 3'(i), 4'(o)} + 8'h21;
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_entry(input bit b, input int i, input int len);
        for (int o = 0; o < IB; o++) begin
            @(negedge clk);
            ld_byte_en = 1; ld_bank = b; ld_index = 3'(i);
            ld_offset = 4'(o); ld_byte = pat(b, i, o);
        end
        @(negedge clk);
        ld_byte_en = 0; ld_len_en = 1; ld_len = 5'(len);
        @(negedge clk);
        ld_len_en = 0;
        mlen[(b ? 8 : 0) + i] = len;
    endtask

    // Issue one access at a falling edge and compare the response one cycle later.
    // Port codes: 0 selector, 1 data, 2 combined, 3 unmapped.
    task automatic access(input logic [1:0] port, input bit wr, input int size,
                          input logic [31:0] wd, input string tag);
        bit ok = 0, sel = 0, rd = 0;
        int rs;
        logic [31:0] d = '0;
        int cnt = 0;
        case (port)
            2'd0: if (wr && size == 2) begin ok = 1; sel = 1; end
            2'd1: if (size >= 1 && size <= DB) begin ok = 1; rd = !wr; end
            2'd2: if (size == 1) begin ok = 1; rd = !wr; end
                  else if (wr && size == 2) begin ok = 1; sel = 1; end
            default: ok = 0;
        endcase
        rs = size;
        if (rd) begin
            for (int g = 0; g < rs; g++) begin
                if (m_valid && (m_off + g) < mlen[(m_bank ? 8 : 0) + m_idx]) begin
                    d[8*(rs-1-g) +: 8] = pat(m_bank, m_idx, m_off + g);
                    cnt++;
                end
            end
        end
        req_valid = 1; req_write = wr; req_port = port;
        req_size = 3'(size); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        check(tag, {rsp_valid, rsp_ok, rsp_rdata}, {1'b1, ok, d});
        if (sel) begin
            m_valid = int'(wd[14:0]) < NE;
            m_bank  = wd[15];
            m_idx   = int'(wd[14:0]) % NE;
            m_off   = 0;
        end else if (rd) begin
            m_off += cnt;
        end
    endtask

    task automatic t_reset();
        check("R10 no response after reset", {33'b0, rsp_valid}, 34'b0);
        access(2'd1, 0, 1, 0, "R1 first read of key 0");
    endtask

    task automatic t_wide();
        access(2'd0, 1, 2, 32'h0001, "R2 select key 1");
        access(2'd1, 0, 4, 0, "R6 four bytes msb first");
        access(2'd1, 0, 4, 0, "R6 partial tail zero pad");
        access(2'd1, 0, 1, 0, "R5 read past end");
        access(2'd1, 0, 2, 0, "R5 past end offset held");
    endtask

    task automatic t_stream();
        access(2'd0, 1, 2, 32'h0003, "R2 select key 3");
        access(2'd1, 0, 1, 0, "R7 stream byte 0");
        access(2'd1, 0, 2, 0, "R7 stream bytes 1-2");
        access(2'd1, 0, 3, 0, "R7 stream bytes 3-5");
        access(2'd1, 0, 4, 0, "R7 stream bytes 6-9");
        access(2'd0, 1, 2, 32'h0003, "R2 reselect mid stream");
        access(2'd1, 0, 1, 0, "R2 offset cleared");
    endtask

    task automatic t_bank();
        access(2'd0, 1, 2, 32'h8001, "R3 select bank 1 entry 1");
        access(2'd1, 0, 4, 0, "R3 bank 1 data");
        access(2'd0, 1, 2, 32'h0001, "R3 select bank 0 entry 1");
        access(2'd1, 0, 1, 0, "R3 bank 0 data");
    endtask

    task automatic t_invalid();
        access(2'd0, 1, 2, 32'h0008, "R4 select index at table size");
        access(2'd1, 0, 4, 0, "R4 invalid read zero");
        access(2'd0, 1, 2, 32'h8009, "R4 select bank 1 beyond");
        access(2'd1, 0, 2, 0, "R4 invalid bank 1 zero");
        access(2'd0, 1, 2, 32'h7FFF, "R4 select top index");
        access(2'd1, 0, 1, 0, "R4 invalid top zero");
    endtask

    task automatic t_empty();
        access(2'd0, 1, 2, 32'h0002, "R5 select empty entry");
        access(2'd1, 0, 4, 0, "R5 zero length read");
    endtask

    task automatic t_selector_refused();
        access(2'd0, 1, 2, 32'h0001, "R2 select key 1");
        access(2'd1, 0, 1, 0, "R2 read byte 0");
        access(2'd0, 1, 4, 32'h0003, "R2 size 4 selector refused");
        access(2'd0, 0, 2, 0, "R2 selector read refused");
        access(2'd1, 0, 1, 0, "R2 selection kept after refusal");
    endtask

    task automatic t_comb();
        access(2'd2, 1, 2, 32'h0003, "R8 combined key select");
        access(2'd2, 0, 1, 0, "R8 combined byte read");
        access(2'd2, 0, 4, 0, "R8 combined wide read refused");
        access(2'd2, 0, 2, 0, "R8 combined 2 byte read refused");
        access(2'd2, 1, 1, 32'h00AA, "R8 combined write dropped");
        access(2'd2, 0, 1, 0, "R8 stream continues");
    endtask

    task automatic t_write_drop();
        access(2'd0, 1, 2, 32'h0000, "R9 select key 0");
        access(2'd1, 1, 4, 32'hDEADBEEF, "R9 data write acknowledged");
        access(2'd1, 0, 4, 0, "R9 contents and offset unchanged");
    endtask

    task automatic t_bad_size();
        access(2'd0, 1, 2, 32'h0001, "R11 select key 1");
        access(2'd1, 0, 0, 0, "R11 size 0 refused");
        access(2'd1, 0, 5, 0, "R11 size 5 refused");
        access(2'd3, 0, 1, 0, "R11 unmapped port refused");
        access(2'd3, 1, 2, 32'h0003, "R11 unmapped select refused");
        access(2'd1, 0, 2, 0, "R11 no effect on offset");
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mlen[k] = 0;
        m_valid = 1; m_bank = 0; m_idx = 0; m_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_pre();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic t_reset_pre();
        check("R10 idle after reset", {33'b0, rsp_valid}, 34'b0);
        load_entry(0, 0, 4);
        load_entry(0, 1, 6);
        load_entry(0, 2, 0);
        load_entry(0, 3, 16);
        load_entry(1, 1, 3);
        t_reset();
        t_wide();
        t_stream();
        t_bank();
        t_invalid();
        t_empty();
        t_selector_refused();
        t_comb();
        t_write_drop();
        t_bad_size();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule